// File: doc/BRIEF.md
# I2C Register Target with Transaction Watchdog

This block is an I2C target that serves reads and writes to a small internal register file. A controller first sends the 7-bit target address with the write direction. It then sends a 16-bit register pointer, high byte first. After that it either writes data bytes, or issues a repeated START and reads bytes back. The pointer advances by one after every data byte. Only the low bits of the pointer select a register, so addresses alias across the register file.

Each transaction has a hard time budget. A cycle counter on the system clock starts at the first START of a transaction. A repeated START does not restart it. When the counter reaches its limit, the target releases SDA and keeps it released until a STOP. A reading controller then sees ones for every remaining bit. The byte in flight may be cut part way through. Acknowledges stop, and late writes are dropped. A sticky status output records the expiry until the next transaction begins.

Top module: `i2c_regtarget_tmo`

## Requirements
- R1: After reset, `sda_oe` is 0, `timed_out` is 0 and every register byte on `regs_o` is 0.
- R2: The target acknowledges an address byte (drives SDA low during the 9th clock) only when its upper 7 bits equal `DEV_ADDR`. Otherwise it does not acknowledge, and the rest of that transfer up to the next START has no effect on the registers.
- R3: In a write transfer (address byte bit 0 = 0), the first two bytes load the 16-bit pointer with the high byte first. Each later byte is stored at register index pointer mod `NREG` and is acknowledged, and the pointer then increments by one.
- R4: In a read transfer (address byte bit 0 = 1), the target sends the register at the current pointer MSB first, then increments the pointer. It keeps sending while the controller acknowledges and stops after a NACK. The pointer survives a repeated START.
- R5: The watchdog starts at the first START of a transaction and expires `TMO_CYCLES` clock cycles later (default 2^18).
- R6: A repeated START inside a transaction neither restarts nor pauses the watchdog.
- R7: From one cycle after expiry until STOP, `sda_oe` stays 0, so every remaining read bit is 1. Bits of the byte in flight that were sent before expiry keep their values.
- R8: After expiry and until STOP, no byte is acknowledged, including address bytes after a repeated START, and no register changes.
- R9: A STOP clears the watchdog and returns the target to idle. The next START begins a fresh time budget.
- R10: `timed_out` rises on expiry. It stays high through the STOP and clears at the first START of the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the watchdog time base |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| timed_out | output | 1 | Sticky watchdog expiry flag |
| regs_o | output | NREG*8 | Register file contents, register i in bits [8i+7:8i] |

## Verification
Some rules are checked on every cycle by the assertions:
- SDA is released one cycle after expiry and stays released.
- The register contents hold still while the watchdog is expired.
- A STOP clears both the watchdog and the drive.
- The counter never passes its limit.
- A repeated START only advances a running count.

Other behaviours only the bench's bus transactions can show:
- Address matching.
- Pointer loading, aliasing and auto-increment.
- Read data placement.
- The boundary between valid bits and forced ones, located by the time of each bit relative to the first START.
- Discarding of late writes.
- The lifetime of the status flag across a STOP and the next START.

// File: rtl/i2ct_pkg.sv
// Shared types for the I2C register target.
// Assumes: nothing beyond a synthesizable SystemVerilog flow.
package i2ct_pkg;

    // Protocol states of the target engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_ACK_DEV,
        ST_WRBYTE,
        ST_ACK_WR,
        ST_RDBYTE,
        ST_ACK_RD,
        ST_DROP
    } tgt_state_e;

    // One-cycle bus events derived from the synchronised lines.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2ct_bus_sync.sv
// Synchronises SCL and SDA and derives START, STOP and SCL edge events.
// Assumes: the bus idles high. Both flop chains reset to 1 so that no
// event is seen at reset.
module i2ct_bus_sync
    import i2ct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LAST = STAGES;

    logic [LAST:0] scl_q;
    logic [LAST:0] sda_q;
    logic          scl_s, scl_d, sda_s, sda_d;

    // Shift both lines through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[LAST-1:0], scl_i};
            sda_q <= {sda_q[LAST-1:0], sda_i};
        end
    end

    assign scl_s = scl_q[LAST-1];
    assign scl_d = scl_q[LAST];
    assign sda_s = sda_q[LAST-1];
    assign sda_d = sda_q[LAST];

    // Decode SDA edges during SCL high as START/STOP, plus SCL edges.
    always_comb begin
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2ct_watchdog.sv
// Transaction watchdog: counts clock cycles from the first START.
// A START that arrives while a count runs (a repeated START) is ignored.
// Expiry holds until STOP. A sticky status bit lasts until the next first START.
// Assumes: start and stop are one-cycle pulses and never occur together.
module i2ct_watchdog #(
    parameter int LIMIT = 2**18,
    parameter int CW    = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic expired,
    output logic status
);

    logic          run;
    logic [CW-1:0] cnt;
    logic          first_start;

    assign first_start = start & ~run & ~expired;

    // Run, count and expire; STOP clears everything but the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            expired <= 1'b0;
            cnt     <= '0;
        end else if (stop) begin
            run     <= 1'b0;
            expired <= 1'b0;
            cnt     <= '0;
        end else if (first_start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == CW'(LIMIT - 1)) begin
                run     <= 1'b0;
                expired <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Sticky expiry flag, cleared when a new transaction begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (first_start) begin
            status <= 1'b0;
        end else if (run && cnt == CW'(LIMIT - 1) && !stop) begin
            status <= 1'b1;
        end
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && !stop && cnt != CW'(LIMIT - 1))
        |=> (run && cnt == CW'($past(cnt) + 1'b1)));

    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!run && !expired));

    assert_status_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> status);

endmodule

// File: rtl/i2ct_regfile.sv
// Byte register file with one write port, one read port and a flat view.
// Assumes: NREG is a power of two; the index is the low pointer bits.
module i2ct_regfile #(
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [7:0]        wdata,
    input  logic [IW-1:0]     ridx,
    output logic [7:0]        rdata,
    output logic [NREG*8-1:0] flat
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [7:0] q;

        // Hold one register byte; load it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && widx == IW'(i)) begin
                q <= wdata;
            end
        end

        assign flat[i*8 +: 8] = q;
    end

    assign rdata = flat[ridx*8 +: 8];

endmodule

// File: rtl/i2c_regtarget_tmo.sv
// I2C target with a 16-bit auto-incrementing register pointer and a
// per-transaction watchdog that forces the target off the bus on expiry.
// Assumes: a single controller, no clock stretching, SCL slow against clk
// (at least several clk cycles per SCL phase).
module i2c_regtarget_tmo
    import i2ct_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3C,
    parameter int         NREG        = 8,
    parameter int         TMO_CYCLES  = 2**18,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              timed_out,
    output logic [NREG*8-1:0] regs_o
);

    localparam int IW = $clog2(NREG);
    localparam int CW = $clog2(TMO_CYCLES);

    bus_ev_t    ev;
    tgt_state_e state;
    logic [3:0] bitcnt;
    logic [7:0] sr;
    logic [7:0] txb;
    logic [1:0] phase;
    logic [15:0] ptr;
    logic       rw;
    logic       nack;
    logic       expired;
    logic       reg_we;
    logic [7:0] rdata;
    logic       byte_done;

    i2ct_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2ct_watchdog #(.LIMIT(TMO_CYCLES), .CW(CW)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ev.start),
        .stop    (ev.stop),
        .expired (expired),
        .status  (timed_out)
    );

    i2ct_regfile #(.NREG(NREG), .IW(IW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .widx  (ptr[IW-1:0]),
        .wdata (sr),
        .ridx  (ptr[IW-1:0]),
        .rdata (rdata),
        .flat  (regs_o)
    );

    assign byte_done = ev.scl_fall && (bitcnt == 4'd8);

    // Store a data byte when its last bit completes in a live write.
    assign reg_we = (state == ST_WRBYTE) && byte_done && (phase == 2'd2)
                    && !expired && !ev.stop && !ev.start;

    // Protocol engine: address match, pointer load, data shift and ACKs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sr     <= '0;
            txb    <= '0;
            phase  <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (expired) begin
            state  <= ST_DROP;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_DEVADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_DEVADDR: begin
                    if (ev.scl_rise) begin
                        sr     <= {sr[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (sr[7:1] == DEV_ADDR) begin
                            sda_oe <= 1'b1;
                            rw     <= sr[0];
                            state  <= ST_ACK_DEV;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    if (ev.scl_fall) begin
                        if (rw) begin
                            txb    <= {rdata[6:0], 1'b0};
                            sda_oe <= ~rdata[7];
                            bitcnt <= 4'd1;
                            ptr    <= ptr + 16'd1;
                            state  <= ST_RDBYTE;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            phase  <= '0;
                            state  <= ST_WRBYTE;
                        end
                    end
                end
                ST_WRBYTE: begin
                    if (ev.scl_rise) begin
                        sr     <= {sr[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        sda_oe <= 1'b1;
                        bitcnt <= '0;
                        state  <= ST_ACK_WR;
                        case (phase)
                            2'd0:    begin ptr[15:8] <= sr; phase <= 2'd1; end
                            2'd1:    begin ptr[7:0]  <= sr; phase <= 2'd2; end
                            default: ptr <= ptr + 16'd1;
                        endcase
                    end
                end
                ST_ACK_WR: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WRBYTE;
                    end
                end
                ST_RDBYTE: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_ACK_RD;
                        end else begin
                            sda_oe <= ~txb[7];
                            txb    <= {txb[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_ACK_RD: begin
                    if (ev.scl_rise) begin
                        nack <= ev.sda;
                    end else if (ev.scl_fall) begin
                        if (nack) begin
                            state <= ST_IDLE;
                        end else begin
                            txb    <= {rdata[6:0], 1'b0};
                            sda_oe <= ~rdata[7];
                            bitcnt <= 4'd1;
                            ptr    <= ptr + 16'd1;
                            state  <= ST_RDBYTE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    assert_release_after_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(expired) |-> !sda_oe);

    assert_regs_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(expired) |-> $stable(regs_o));

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> !sda_oe);

endmodule

// File: tb/i2c_regtarget_tmo_tb.sv
module i2c_regtarget_tmo_tb;

    localparam int         NREG = 8;
    localparam int         TMO  = 4000;
    localparam int         Q    = 10;
    localparam int         MARG = 12;
    localparam logic [6:0] DEV  = 7'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic sda_oe, timed_out;
    logic [NREG*8-1:0] regs;
    logic scl_line, sda_line;

    assign scl_line = ~m_scl_low;
    assign sda_line = ~(m_sda_low | sda_oe);

    i2c_regtarget_tmo #(
        .DEV_ADDR(DEV), .NREG(NREG), .TMO_CYCLES(TMO), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe(sda_oe), .timed_out(timed_out), .regs_o(regs)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int dl = 0;
    logic [7:0] mexp [NREG];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start(input bit first);
        m_sda_low = 1'b0; wq();
        m_scl_low = 1'b0; wq();
        m_sda_low = 1'b1;
        if (first) dl = cyc + TMO + 3;
        wq();
        m_scl_low = 1'b1; wq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq();
        m_scl_low = 1'b0; wq();
        m_sda_low = 1'b0; wq(); wq();
    endtask

    task automatic send_bit(input bit b);
        wq(); m_sda_low = ~b; wq();
        m_scl_low = 1'b0; wq(); wq();
        m_scl_low = 1'b1;
    endtask

    task automatic get_bit(output bit b, output int t);
        wq(); m_sda_low = 1'b0; wq();
        m_scl_low = 1'b0; wq();
        b = sda_line; t = cyc;
        wq();
        m_scl_low = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack, output int t8);
        bit b; int t;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        t8 = cyc;
        get_bit(b, t);
        ack = ~b;
    endtask

    // Read a byte; expected bit is data before the deadline, 1 after (R7).
    task automatic recv_chk(input logic [7:0] exp, input bit last, input string req);
        bit b; int t;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, t);
            if (t < dl - MARG) chk(b == exp[i], req, b, exp[i]);
            else if (t > dl + MARG) chk(b == 1'b1, "R7 forced one", b, 1);
        end
        send_bit(last);
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 29 + k * 53 + 7) & 8'h7F);
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(regs[i*8 +: 8] == mexp[i], req, regs[i*8 +: 8], mexp[i]);
    endtask

    task automatic write_seq(input logic [15:0] a, input int n, input int seed);
        bit ack; int t8; int amb; logic [7:0] ambv, ambold;
        amb = -1; ambv = '0; ambold = '0;
        bus_start(1);
        send_byte({DEV, 1'b0}, ack, t8); chk(ack, "R2 address ack", ack, 1);
        send_byte(a[15:8], ack, t8);    chk(ack, "R3 pointer hi ack", ack, 1);
        send_byte(a[7:0], ack, t8);     chk(ack, "R3 pointer lo ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            int idx;
            v = pat(seed, k);
            idx = (int'(a) + k) % NREG;
            send_byte(v, ack, t8);
            if (t8 + 3 < dl - MARG) begin
                mexp[idx] = v;
                chk(ack, "R3 data ack", ack, 1);
            end else if (t8 + 3 > dl + MARG) begin
                chk(!ack, "R8 no ack after expiry", ack, 0);
            end else begin
                amb = idx; ambv = v; ambold = mexp[idx];
            end
        end
        bus_stop();
        if (amb >= 0) begin
            chk(regs[amb*8 +: 8] == ambv || regs[amb*8 +: 8] == ambold,
                "R8 boundary byte", regs[amb*8 +: 8], ambv);
            mexp[amb] = regs[amb*8 +: 8];
        end
    endtask

    task automatic read_seq(input logic [15:0] a, input int n);
        bit ack; int t8;
        bus_start(1);
        send_byte({DEV, 1'b0}, ack, t8); chk(ack, "R2 address ack", ack, 1);
        send_byte(a[15:8], ack, t8);
        send_byte(a[7:0], ack, t8);
        bus_start(0);
        send_byte({DEV, 1'b1}, ack, t8); chk(ack, "R4 read address ack", ack, 1);
        for (int k = 0; k < n; k++)
            recv_chk(mexp[(int'(a) + k) % NREG], k == n - 1, "R4 read data");
        bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack; int t8;
        for (int i = 0; i < NREG; i++) mexp[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(timed_out == 1'b0, "R1 timed_out", timed_out, 0);
        check_regs("R1 register reset");

        // R3: single-byte writes to every register, upper pointer bits set.
        for (int a = 0; a < NREG; a++) begin
            write_seq(16'((16'h0137 * a) << 3) | 16'(a), 1, a + 1);
            check_regs("R3 single write");
            chk(timed_out == 1'b0, "R9 no expiry on short write", timed_out, 0);
        end

        // R3: auto-increment that wraps past the last register.
        write_seq(16'h4A06, 3, 20);
        check_regs("R3 auto-increment wrap");

        // R2: wrong device address is not acknowledged and writes nothing.
        bus_start(1);
        send_byte({DEV ^ 7'h01, 1'b0}, ack, t8); chk(!ack, "R2 foreign address nack", ack, 0);
        send_byte(8'h00, ack, t8); chk(!ack, "R2 ignored byte", ack, 0);
        send_byte(8'h02, ack, t8);
        send_byte(8'h55, ack, t8);
        bus_stop();
        check_regs("R2 foreign write ignored");

        // R4, R9: combined reads from every start index, back to back.
        for (int a = 0; a < NREG; a++) begin
            read_seq(16'hF000 | 16'(a), 2);
            chk(timed_out == 1'b0, "R9 fresh budget per transaction", timed_out, 0);
        end

        // R5, R6, R7: long read runs past the deadline; repeated START inside.
        bus_start(1);
        send_byte({DEV, 1'b0}, ack, t8);
        send_byte(8'h00, ack, t8);
        send_byte(8'h01, ack, t8);
        bus_start(0);
        send_byte({DEV, 1'b1}, ack, t8); chk(ack, "R4 read address ack", ack, 1);
        for (int k = 0; k < 14; k++)
            recv_chk(mexp[(1 + k) % NREG], 1'b0, "R6 data before deadline");
        chk(timed_out == 1'b1, "R10 status set", timed_out, 1);
        // R8: address after a repeated START is ignored once expired.
        bus_start(0);
        send_byte({DEV, 1'b0}, ack, t8); chk(!ack, "R8 address ignored", ack, 0);
        bus_stop();
        chk(timed_out == 1'b1, "R10 status held after stop", timed_out, 1);

        // R8: long write; bytes after the deadline are discarded.
        write_seq(16'h0000, 12, 40);
        check_regs("R8 late writes discarded");

        // R10, R9: a new transaction clears status and runs normally.
        bus_start(1);
        chk(timed_out == 1'b0, "R10 status cleared by start", timed_out, 0);
        send_byte({DEV, 1'b0}, ack, t8); chk(ack, "R9 target back in service", ack, 1);
        bus_stop();
        read_seq(16'h0003, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule